// File: doc/BRIEF.md
# Signed/Unsigned 64-bit Multiply-Accumulate Unit

This unit forms the full double-width product of two 32-bit operands and adds it to a 64-bit accumulator value supplied as a low word and a high word. A single mode input chooses whether the operands and the accumulator are treated as unsigned or as two's-complement numbers. The 64-bit total comes back as a low word and a high word. An overflow flag describes the accumulate step in the chosen mode. The multiply itself cannot overflow, so it adds nothing to the flag.

The caller raises `start` for one cycle with the operands present. The unit captures everything on that edge and runs on its own. The product is built a chunk of the multiplier at a time. The accumulate is then done as two word-wide additions that share one adder: the low words first, then the high words with the captured carry. The results and a one-cycle `done` appear together. They stay unchanged until the next operation completes. A `start` that arrives while an operation is running is dropped.

Top module: `mac64_accum`

## Requirements
- R1: While `rst_n` is low, and after it is released until the first operation completes, `done`, `ovf`, `res_lo` and `res_hi` are all 0.
- R2: `done` is high for exactly one cycle. It rises on the (2*OP_W/CHUNK_W + 2)-th rising edge after the edge that accepted `start`, which is 6 edges at the default parameters.
- R3: With `mode`=0 (unsigned), {`res_hi`,`res_lo`} equals the zero-extended product `a`*`b` plus {`acc_hi`,`acc_lo`}, modulo 2^64. `res_lo` holds bits 31:0 and `res_hi` holds bits 63:32.
- R4: With `mode`=1 (signed), {`res_hi`,`res_lo`} equals the product of the sign-extended `a` and `b` plus {`acc_hi`,`acc_lo`}, modulo 2^64.
- R5: With `mode`=0, `ovf` is the carry out of the upper-word addition. This means the true unsigned sum is at least 2^64.
- R6: With `mode`=1, `ovf` is set when the upper-word addition overflows in two's complement. This means the signed 64-bit sum falls outside [-2^63, 2^63-1].
- R7: A carry out of the low-word addition is added into the high word. For example, 1*1 plus 0x00000000_FFFFFFFF gives 0x00000001_00000000.
- R8: All operands and `mode` are taken from the accepting edge. A `start` or any input change while an operation is in progress has no effect on that result, and it produces no additional `done`.
- R9: `res_lo`, `res_hi` and `ovf` change only on the edge that raises `done`. At all other times they hold their values, whatever the inputs do.
- R10: The same operand bit patterns produce different results in the two modes. For example, a=0xFFFFFFFF, b=2, accumulator 0 gives 0x00000001_FFFFFFFE with `mode`=0 and 0xFFFFFFFF_FFFFFFFE with `mode`=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Request pulse; accepted only when idle |
| mode | input | 1 | 0 = unsigned, 1 = signed |
| a | input | OP_W | Multiplicand |
| b | input | OP_W | Multiplier |
| acc_lo | input | OP_W | Accumulator low word |
| acc_hi | input | OP_W | Accumulator high word |
| res_lo | output | OP_W | Result low word |
| res_hi | output | OP_W | Result high word |
| ovf | output | 1 | Accumulate overflow for the selected mode |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the unit at its defaults: 32-bit operands with a 16-bit chunk, so four multiply steps and a latency of six edges. This width lets the bench hit the exact word boundaries the requirements name. It covers the low-word carry into the high word, the unsigned carry out at 2^64, and both signed limits around the most negative operand. It also runs the same bit patterns in both modes, so a mix-up in sign extension or in the choice of overflow rule shows up as a wrong word at the ports.

// File: rtl/mac_pkg.sv
`timescale 1ns/1ps
package mac_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_MUL    = 2'd1,
    ST_ADD_LO = 2'd2,
    ST_ADD_HI = 2'd3
  } mac_state_e;

endpackage

// File: rtl/mac_rst_sync.sv
`timescale 1ns/1ps
// Asynchronous assert, synchronous release of the active-low reset.
module mac_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/mac_word_adder.sv
`timescale 1ns/1ps
// One word-wide adder with carry in; reports carry out and signed overflow.
module mac_word_adder #(
  parameter int W = 32
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout,
  output logic         sovf
);

  logic [W:0] wide;

  always_comb begin
    wide = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, cin};
    sum  = wide[W-1:0];
    cout = wide[W];
    sovf = (x[W-1] == y[W-1]) && (wide[W-1] != x[W-1]);
  end

endmodule

// File: rtl/mac_seq_mult.sv
`timescale 1ns/1ps
// Iterative multiplier: retires CHUNK_W multiplier bits per step,
// result taken modulo 2^PROD_W of the (already extended) operands.
module mac_seq_mult #(
  parameter int PROD_W  = 64,
  parameter int CHUNK_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step,
  input  logic [PROD_W-1:0] mcand_in,
  input  logic [PROD_W-1:0] mplier_in,
  output logic [PROD_W-1:0] product
);

  logic [PROD_W-1:0] mcand_q,  mcand_d;
  logic [PROD_W-1:0] mplier_q, mplier_d;
  logic [PROD_W-1:0] prod_q,   prod_d;
  logic [PROD_W-1:0] term [CHUNK_W];
  logic [PROD_W-1:0] partial;

  // One shifted copy of the multiplicand per multiplier bit in the chunk.
  for (genvar gi = 0; gi < CHUNK_W; gi++) begin : g_term
    assign term[gi] = mplier_q[gi] ? (mcand_q << gi) : '0;
  end

  always_comb begin
    partial = '0;
    for (int i = 0; i < CHUNK_W; i++) begin
      partial = partial + term[i];
    end
  end

  always_comb begin
    mcand_d  = mcand_q;
    mplier_d = mplier_q;
    prod_d   = prod_q;
    if (load) begin
      mcand_d  = mcand_in;
      mplier_d = mplier_in;
      prod_d   = '0;
    end else if (step) begin
      prod_d   = prod_q + partial;
      mcand_d  = mcand_q << CHUNK_W;
      mplier_d = mplier_q >> CHUNK_W;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mcand_q  <= '0;
      mplier_q <= '0;
      prod_q   <= '0;
    end else begin
      mcand_q  <= mcand_d;
      mplier_q <= mplier_d;
      prod_q   <= prod_d;
    end
  end

  assign product = prod_q;

endmodule

// File: rtl/mac_ctrl.sv
`timescale 1ns/1ps
// Sequencer: accept, NSTEP multiply steps, low-word add, high-word add.
module mac_ctrl
  import mac_pkg::*;
#(
  parameter int NSTEP = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic load,
  output logic step,
  output logic add_lo_en,
  output logic add_hi_en,
  output logic busy,
  output logic done
);

  localparam int CNT_W = (NSTEP > 1) ? $clog2(NSTEP) : 1;

  mac_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q,   cnt_d;
  logic             done_q,  done_d;
  logic             last_step;

  assign last_step = (cnt_q == CNT_W'(NSTEP - 1));

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d = ST_MUL;
          cnt_d   = '0;
        end
      end
      ST_MUL: begin
        if (last_step) state_d = ST_ADD_LO;
        else           cnt_d   = cnt_q + 1'b1;
      end
      ST_ADD_LO: state_d = ST_ADD_HI;
      ST_ADD_HI: state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  assign load      = (state_q == ST_IDLE) && start;
  assign step      = (state_q == ST_MUL);
  assign add_lo_en = (state_q == ST_ADD_LO);
  assign add_hi_en = (state_q == ST_ADD_HI);
  assign busy      = (state_q != ST_IDLE);

  always_comb begin
    done_d = add_hi_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      done_q  <= done_d;
    end
  end

  assign done = done_q;

endmodule

// File: rtl/mac64_accum.sv
`timescale 1ns/1ps
// Multiply-accumulate top: double-width product plus accumulator,
// accumulate split into two word additions on one shared adder.
module mac64_accum #(
  parameter int OP_W    = 32,
  parameter int CHUNK_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            mode,
  input  logic [OP_W-1:0] a,
  input  logic [OP_W-1:0] b,
  input  logic [OP_W-1:0] acc_lo,
  input  logic [OP_W-1:0] acc_hi,
  output logic [OP_W-1:0] res_lo,
  output logic [OP_W-1:0] res_hi,
  output logic            ovf,
  output logic            done
);

  localparam int PROD_W = 2 * OP_W;
  localparam int NSTEP  = PROD_W / CHUNK_W;

  logic rst_sync_n;
  logic load, step, add_lo_en, add_hi_en, busy;

  mac_rst_sync #(.STAGES(2)) rst_sync_i (
    .clk        (clk),
    .arst_n     (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  mac_ctrl #(.NSTEP(NSTEP)) ctrl_i (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .start     (start),
    .load      (load),
    .step      (step),
    .add_lo_en (add_lo_en),
    .add_hi_en (add_hi_en),
    .busy      (busy),
    .done      (done)
  );

  // Operand extension by mode: sign bits in signed mode, zeros otherwise.
  logic [PROD_W-1:0] a_ext, b_ext;
  assign a_ext = {{OP_W{mode & a[OP_W-1]}}, a};
  assign b_ext = {{OP_W{mode & b[OP_W-1]}}, b};

  logic [PROD_W-1:0] product;

  mac_seq_mult #(.PROD_W(PROD_W), .CHUNK_W(CHUNK_W)) mult_i (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .load      (load),
    .step      (step),
    .mcand_in  (a_ext),
    .mplier_in (b_ext),
    .product   (product)
  );

  // Captured operation context.
  logic            mode_q,   mode_d;
  logic [OP_W-1:0] acc_lo_q, acc_lo_d;
  logic [OP_W-1:0] acc_hi_q, acc_hi_d;

  always_comb begin
    mode_d   = mode_q;
    acc_lo_d = acc_lo_q;
    acc_hi_d = acc_hi_q;
    if (load) begin
      mode_d   = mode;
      acc_lo_d = acc_lo;
      acc_hi_d = acc_hi;
    end
  end

  // Shared word adder: low halves first, then high halves with carry.
  logic [OP_W-1:0] add_x, add_y, add_sum;
  logic            add_cin, add_cout, add_sovf;

  always_comb begin
    if (add_hi_en) begin
      add_x   = product[PROD_W-1:OP_W];
      add_y   = acc_hi_q;
      add_cin = carry_q;
    end else begin
      add_x   = product[OP_W-1:0];
      add_y   = acc_lo_q;
      add_cin = 1'b0;
    end
  end

  mac_word_adder #(.W(OP_W)) adder_i (
    .x    (add_x),
    .y    (add_y),
    .cin  (add_cin),
    .sum  (add_sum),
    .cout (add_cout),
    .sovf (add_sovf)
  );

  logic [OP_W-1:0] lo_sum_q, lo_sum_d;
  logic            carry_q,  carry_d;
  logic [OP_W-1:0] res_lo_q, res_lo_d;
  logic [OP_W-1:0] res_hi_q, res_hi_d;
  logic            ovf_q,    ovf_d;

  always_comb begin
    lo_sum_d = lo_sum_q;
    carry_d  = carry_q;
    res_lo_d = res_lo_q;
    res_hi_d = res_hi_q;
    ovf_d    = ovf_q;
    if (add_lo_en) begin
      lo_sum_d = add_sum;
      carry_d  = add_cout;
    end
    if (add_hi_en) begin
      res_lo_d = lo_sum_q;
      res_hi_d = add_sum;
      ovf_d    = mode_q ? add_sovf : add_cout;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      mode_q   <= 1'b0;
      acc_lo_q <= '0;
      acc_hi_q <= '0;
      lo_sum_q <= '0;
      carry_q  <= 1'b0;
      res_lo_q <= '0;
      res_hi_q <= '0;
      ovf_q    <= 1'b0;
    end else begin
      mode_q   <= mode_d;
      acc_lo_q <= acc_lo_d;
      acc_hi_q <= acc_hi_d;
      lo_sum_q <= lo_sum_d;
      carry_q  <= carry_d;
      res_lo_q <= res_lo_d;
      res_hi_q <= res_hi_d;
      ovf_q    <= ovf_d;
    end
  end

  assign res_lo = res_lo_q;
  assign res_hi = res_hi_q;
  assign ovf    = ovf_q;

endmodule

// File: rtl/mac64_accum_chk.sv
`timescale 1ns/1ps
// Property checker for mac64_accum, attached by bind below.
module mac64_accum_chk #(
  parameter int OP_W    = 32,
  parameter int CHUNK_W = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic            mode,
  input logic [OP_W-1:0] a,
  input logic [OP_W-1:0] b,
  input logic [OP_W-1:0] acc_lo,
  input logic [OP_W-1:0] acc_hi,
  input logic [OP_W-1:0] res_lo,
  input logic [OP_W-1:0] res_hi,
  input logic            ovf,
  input logic            done,
  input logic            busy
);

  localparam int PROD_W = 2 * OP_W;
  localparam int LAT    = PROD_W / CHUNK_W + 2;
  localparam int SW     = $clog2(LAT + 2) + 1;

  logic              accept;
  logic [PROD_W-1:0] ea, eb, p, acc_w;
  logic [PROD_W:0]   tot;
  logic              exp_ovf_now;

  assign accept = start && !busy;

  always_comb begin
    ea          = mode ? {{OP_W{a[OP_W-1]}}, a} : {{OP_W{1'b0}}, a};
    eb          = mode ? {{OP_W{b[OP_W-1]}}, b} : {{OP_W{1'b0}}, b};
    p           = ea * eb;
    acc_w       = {acc_hi, acc_lo};
    tot         = {1'b0, p} + {1'b0, acc_w};
    exp_ovf_now = mode ? ((p[PROD_W-1] == acc_w[PROD_W-1]) &&
                          (tot[PROD_W-1] != p[PROD_W-1]))
                       : tot[PROD_W];
  end

  logic              pend_q;
  logic [SW-1:0]     since_q;
  logic [PROD_W-1:0] exp_res_q;
  logic              exp_ovf_q;
  logic              exp_mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q     <= 1'b0;
      since_q    <= '0;
      exp_res_q  <= '0;
      exp_ovf_q  <= 1'b0;
      exp_mode_q <= 1'b0;
    end else begin
      if (accept) begin
        pend_q     <= 1'b1;
        since_q    <= '0;
        exp_res_q  <= tot[PROD_W-1:0];
        exp_ovf_q  <= exp_ovf_now;
        exp_mode_q <= mode;
      end else begin
        if (done) pend_q <= 1'b0;
        if (pend_q && (since_q != '1)) since_q <= since_q + 1'b1;
      end
    end
  end

  // R2: completion is a single-cycle pulse
  a_r2_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R2, R8: done only for an accepted request, after exactly LAT edges
  a_r2_latency: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (pend_q && (since_q == SW'(LAT))));

  // R3, R7
  a_r3_unsigned_result: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !exp_mode_q) |-> ({res_hi, res_lo} == exp_res_q));

  // R4, R7
  a_r4_signed_result: assert property (@(posedge clk) disable iff (!rst_n)
    (done && exp_mode_q) |-> ({res_hi, res_lo} == exp_res_q));

  a_r5_unsigned_ovf: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !exp_mode_q) |-> (ovf == exp_ovf_q));

  a_r6_signed_ovf: assert property (@(posedge clk) disable iff (!rst_n)
    (done && exp_mode_q) |-> (ovf == exp_ovf_q));

  // R9, R1: outputs move only with done
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable({res_hi, res_lo, ovf}));

endmodule

bind mac64_accum mac64_accum_chk #(.OP_W(OP_W), .CHUNK_W(CHUNK_W)) chk_i (
  .clk    (clk),
  .rst_n  (rst_sync_n),
  .start  (start),
  .mode   (mode),
  .a      (a),
  .b      (b),
  .acc_lo (acc_lo),
  .acc_hi (acc_hi),
  .res_lo (res_lo),
  .res_hi (res_hi),
  .ovf    (ovf),
  .done   (done),
  .busy   (busy)
);

// File: tb/mac64_accum_tb_top.sv
`timescale 1ns/1ps
module mac64_accum_tb_top;

  localparam int OP_W    = 32;
  localparam int CHUNK_W = 16;
  localparam int LAT     = 2 * OP_W / CHUNK_W + 2;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            start = 1'b0;
  logic            mode = 1'b0;
  logic [OP_W-1:0] a = '0, b = '0, acc_lo = '0, acc_hi = '0;
  logic [OP_W-1:0] res_lo, res_hi;
  logic            ovf, done;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  mac64_accum #(.OP_W(OP_W), .CHUNK_W(CHUNK_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
    .a(a), .b(b), .acc_lo(acc_lo), .acc_hi(acc_hi),
    .res_lo(res_lo), .res_hi(res_hi), .ovf(ovf), .done(done)
  );

  task automatic chk(input bit ok, input string req,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Expected value from the requirement text (R3..R6).
  task automatic model(input logic m, input logic [31:0] ia, ib, ihi, ilo,
                       output logic [63:0] r, output logic ov);
    logic [63:0] ea, eb, p, ac;
    logic [64:0] s;
    ea = m ? {{32{ia[31]}}, ia} : {32'd0, ia};
    eb = m ? {{32{ib[31]}}, ib} : {32'd0, ib};
    p  = ea * eb;
    ac = {ihi, ilo};
    s  = {1'b0, p} + {1'b0, ac};
    r  = s[63:0];
    ov = m ? ((p[63] == ac[63]) && (r[63] != p[63])) : s[64];
  endtask

  task automatic run_op(input logic m, input logic [31:0] ia, ib, ihi, ilo,
                        input bit inject,
                        output logic [63:0] got, output logic got_ovf);
    logic [63:0] er;
    logic        eo;
    int          lat;
    model(m, ia, ib, ihi, ilo, er, eo);
    @(negedge clk);
    mode = m; a = ia; b = ib; acc_hi = ihi; acc_lo = ilo; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    for (int j = 1; j <= LAT + 4; j++) begin
      if (inject && j == 2) begin
        a = ~a; b = b ^ 32'h5A5A_0F0F; acc_lo = acc_lo + 1;
        acc_hi = ~acc_hi; mode = ~mode; start = 1'b1;   // R8 stimulus
      end
      if (inject && j == 3) start = 1'b0;
      @(negedge clk);
      if (done) begin
        lat = j;
        break;
      end
    end
    chk(lat == LAT, "R2 latency", 64'(lat), 64'(LAT));
    got     = {res_hi, res_lo};
    got_ovf = ovf;
    chk(got == er, m ? "R4 signed result" : "R3 unsigned result", got, er);
    chk(got_ovf == eo, m ? "R6 signed ovf" : "R5 unsigned ovf",
        64'(got_ovf), 64'(eo));
    @(negedge clk);
    chk(!done, "R2 done one cycle", 64'(done), 64'd0);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    chk(done == 1'b0 && ovf == 1'b0, "R1 flags in reset", {ovf, done}, 64'd0);
    chk({res_hi, res_lo} == 64'd0, "R1 result in reset", {res_hi, res_lo}, 64'd0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(done == 1'b0 && ovf == 1'b0 && {res_hi, res_lo} == 64'd0,
        "R1 after release", {res_hi, res_lo}, 64'd0);
  endtask

  task automatic t_unsigned_basic;
    logic [63:0] r; logic o;
    run_op(1'b0, 32'd3, 32'd5, 32'd0, 32'd7, 1'b0, r, o);
    chk(r == 64'd22, "R3 small sum", r, 64'd22);
    run_op(1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'd0, 32'd0, 1'b0, r, o);
    chk(o == 1'b0, "R5 max product no carry", 64'(o), 64'd0);
  endtask

  task automatic t_carry_link;
    logic [63:0] r; logic o;
    run_op(1'b0, 32'd1, 32'd1, 32'd0, 32'hFFFF_FFFF, 1'b0, r, o);
    chk(r == 64'h1_0000_0000, "R7 low carry into high", r, 64'h1_0000_0000);
    run_op(1'b1, 32'd1, 32'd1, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 1'b0, r, o);
    chk(o == 1'b1, "R7 R6 carry drives signed ovf", 64'(o), 64'd1);
  endtask

  task automatic t_unsigned_ovf;
    logic [63:0] r; logic o;
    run_op(1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF,
           1'b0, r, o);
    chk(o == 1'b1, "R5 carry out of upper word", 64'(o), 64'd1);
    run_op(1'b0, 32'd0, 32'd9, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, r, o);
    chk(o == 1'b0, "R5 all ones no carry", 64'(o), 64'd0);
  endtask

  task automatic t_signed;
    logic [63:0] r; logic o;
    run_op(1'b1, 32'hFFFF_FFFD, 32'd5, 32'd0, 32'd20, 1'b0, r, o);
    chk(r == 64'd5, "R4 -3*5+20", r, 64'd5);
    run_op(1'b1, 32'hFFFF_FFFF, 32'd1, 32'd0, 32'd1, 1'b0, r, o);
    chk(r == 64'd0 && o == 1'b0, "R6 wrap is not signed ovf", {r[62:0], o}, 64'd0);
  endtask

  task automatic t_signed_ovf;
    logic [63:0] r; logic o;
    run_op(1'b1, 32'h8000_0000, 32'h8000_0000, 32'h7FFF_FFFF, 32'hFFFF_FFFF,
           1'b0, r, o);
    chk(o == 1'b1, "R6 positive overflow", 64'(o), 64'd1);
    run_op(1'b1, 32'h8000_0000, 32'h7FFF_FFFF, 32'h8000_0000, 32'd0,
           1'b0, r, o);
    chk(o == 1'b1, "R6 negative overflow", 64'(o), 64'd1);
  endtask

  task automatic t_mode_select;
    logic [63:0] r; logic o;
    run_op(1'b0, 32'hFFFF_FFFF, 32'd2, 32'd0, 32'd0, 1'b0, r, o);
    chk(r == 64'h1_FFFF_FFFE, "R10 unsigned view", r, 64'h1_FFFF_FFFE);
    run_op(1'b1, 32'hFFFF_FFFF, 32'd2, 32'd0, 32'd0, 1'b0, r, o);
    chk(r == 64'hFFFF_FFFF_FFFF_FFFE, "R10 signed view", r, 64'hFFFF_FFFF_FFFF_FFFE);
  endtask

  task automatic t_busy_ignore;
    logic [63:0] r; logic o;
    int extra;
    run_op(1'b0, 32'h1234_5678, 32'h9ABC_DEF0, 32'h0000_0011, 32'h2222_2222,
           1'b1, r, o);
    extra = 0;
    for (int j = 0; j < LAT + 2; j++) begin
      @(negedge clk);
      if (done) extra++;
    end
    chk(extra == 0, "R8 no second done", 64'(extra), 64'd0);
  endtask

  task automatic t_hold;
    logic [63:0] r, held; logic o, held_o;
    int seen;
    run_op(1'b1, 32'h0000_0007, 32'hFFFF_FFF0, 32'h1, 32'h2, 1'b0, r, o);
    held = {res_hi, res_lo}; held_o = ovf;
    seen = 0;
    for (int j = 0; j < 10; j++) begin
      @(negedge clk);
      a = a + 32'd3; b = ~b; acc_hi = acc_hi ^ 32'hF0F0_F0F0; mode = ~mode;
      if (done) seen++;
    end
    chk({res_hi, res_lo} == held && ovf == held_o, "R9 outputs hold",
        {res_hi, res_lo}, held);
    chk(seen == 0, "R9 no done without start", 64'(seen), 64'd0);
  endtask

  task automatic t_sweep;
    logic [31:0] s = 32'hC0FF_EE11;
    logic [31:0] v [4];
    logic [63:0] r; logic o;
    for (int n = 0; n < 24; n++) begin
      for (int k = 0; k < 4; k++) begin
        s = s ^ (s << 13); s = s ^ (s >> 17); s = s ^ (s << 5);
        v[k] = s;
      end
      run_op(n[0], v[0], v[1], v[2], v[3], 1'b0, r, o);  // R3 / R4 sweep
    end
  endtask

  initial begin
    t_reset();
    t_unsigned_basic();
    t_carry_link();
    t_unsigned_ovf();
    t_signed();
    t_signed_ovf();
    t_mode_select();
    t_busy_ignore();
    t_hold();
    t_sweep();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule